// File: doc/BRIEF.md
# Per-Lane Variable Arithmetic Right Shifter

This unit is a packed SIMD datapath stage. A 128-bit data vector and a 128-bit count vector arrive together. Each vector is cut into four 32-bit lanes. Every data lane is shifted right arithmetically by the amount held in the count lane at the same position, and the vacated high bits take the lane's sign. The four results fill the low 128 bits of a wider destination, and every destination bit above bit 127 reads zero.

Each count lane is treated as a full 32-bit unsigned number. No lane looks only at its low five bits, and the top lane follows the same rule as the others. Any count of 32 or more therefore fills the lane with copies of its sign bit. The stage has one register: a result and its valid flag appear one clock after the operands are presented.

Top module: `vsra_unit`

## Requirements
- R1: Each result lane i (bits 32i+31:32i) is data lane i shifted right by count lane i, for counts 0 to 31, with the vacated high bits filled with data bit 32i+31. It does not depend on any other lane.
- R2: A count lane of 32 or more, read as a full 32-bit unsigned value, gives 0xFFFFFFFF when the data lane's bit 31 is set and 0x00000000 when it is clear. This includes counts whose low five bits are zero, such as 0x20 and 0x100, and it applies to every lane including bits 127:96.
- R3: A count lane of zero passes its data lane through unchanged.
- R4: A data lane of zero gives a zero result lane for any count.
- R5: Result bits DEST_W-1 down to 128 are always zero.
- R6: `validOut` is high in exactly the cycle after a cycle in which `validIn` was high outside reset.
- R7: A synchronous reset clears `validOut` and the whole result register at the next clock.
- R8: On a clock where `validIn` is low and reset is not asserted, the result register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Operands on dataIn and countIn are valid |
| dataIn | input | 128 | Four 32-bit signed data lanes |
| countIn | input | 128 | Four 32-bit unsigned shift counts |
| validOut | output | 1 | resultOut holds a new result |
| resultOut | output | DEST_W | Shifted lanes in bits 127:0, zeros above |

## Verification
A count decoder that ignores the upper count bits shows up in the very next result as a lane that has not saturated. The clearest case is a count of 0x20 or 0x100, which would return the unshifted data, or a positive lane that keeps some low bits. A valid flag or load strobe stuck in the wrong state appears one clock later, either as `validOut` out of step with `validIn` or as a result that changes while idle or survives a reset. Rotating every vector across all four lanes exposes a lane that is wired to its neighbour's count or data on the first vector that sits in that lane.

// File: rtl/vsra_pkg.sv
package vsra_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero the result register
    logic load;    // capture a new result
  } sraStrobe_t;
endpackage

// File: rtl/vsra_lane.sv
module vsra_lane #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] laneData,
  input  logic [LANE_W-1:0] laneCount,
  output logic [LANE_W-1:0] laneRes
);
  localparam int SH_W = $clog2(LANE_W);

  logic overRange;
  logic [SH_W-1:0] shAmt;

  // any bit above the in-range field means count >= LANE_W
  assign overRange = |laneCount[LANE_W-1:SH_W];
  assign shAmt     = laneCount[SH_W-1:0];

  always_comb begin
    if (overRange)
      laneRes = {LANE_W{laneData[LANE_W-1]}};
    else
      laneRes = $unsigned($signed(laneData) >>> shAmt);
  end
endmodule

// File: rtl/vsra_ctrl.sv
module vsra_ctrl
  import vsra_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  output sraStrobe_t strobe,
  output logic       validOut
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = validIn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end
endmodule

// File: rtl/vsra_datapath.sv
module vsra_datapath
  import vsra_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  parameter int DEST_W = 256
) (
  input  logic                    clk,
  input  sraStrobe_t              strobe,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic [LANES*LANE_W-1:0] countIn,
  output logic [DEST_W-1:0]       resultOut
);
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] laneOut;
  logic [DEST_W-1:0] nextRes;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    vsra_lane #(.LANE_W(LANE_W)) u_lane (
      .laneData (dataIn [g*LANE_W +: LANE_W]),
      .laneCount(countIn[g*LANE_W +: LANE_W]),
      .laneRes  (laneOut[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    nextRes = '0;
    nextRes[DATA_W-1:0] = laneOut;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     resultOut <= '0;
    else if (strobe.load) resultOut <= nextRes;
  end
endmodule

// File: rtl/vsra_unit.sv
module vsra_unit
  import vsra_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  parameter int DEST_W = 256   // must be at least LANES*LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    validIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic [LANES*LANE_W-1:0] countIn,
  output logic                    validOut,
  output logic [DEST_W-1:0]       resultOut
);
  sraStrobe_t strobe;

  vsra_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .strobe  (strobe),
    .validOut(validOut)
  );

  vsra_datapath #(.LANE_W(LANE_W), .LANES(LANES), .DEST_W(DEST_W)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .countIn  (countIn),
    .resultOut(resultOut)
  );
endmodule

// File: rtl/vsra_chk.sv
module vsra_chk #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  parameter int DEST_W = 256
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    validIn,
  input logic [LANES*LANE_W-1:0] dataIn,
  input logic [LANES*LANE_W-1:0] countIn,
  input logic                    validOut,
  input logic [DEST_W-1:0]       resultOut
);
  localparam int DATA_W = LANES * LANE_W;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!validOut && resultOut == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> $stable(resultOut));
  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    validIn |=> ((resultOut >> DATA_W) == '0));

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    // R2
    lane_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (validIn && countIn[g*LANE_W +: LANE_W] >= LANE_W) |=>
      (resultOut[g*LANE_W +: LANE_W] ==
       {LANE_W{$past(dataIn[g*LANE_W + LANE_W - 1])}}));
    // R3
    lane_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (validIn && countIn[g*LANE_W +: LANE_W] == '0) |=>
      (resultOut[g*LANE_W +: LANE_W] == $past(dataIn[g*LANE_W +: LANE_W])));
  end
endmodule

bind vsra_unit vsra_chk #(.LANE_W(LANE_W), .LANES(LANES), .DEST_W(DEST_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .dataIn   (dataIn),
  .countIn  (countIn),
  .validOut (validOut),
  .resultOut(resultOut)
);

// File: tb/sim_vsra_unit.sv
module sim_vsra_unit;
  localparam int DEST_W = 256;
  localparam int NV = 18;

  // {data, count, expected}
  localparam logic [95:0] VEC [NV] = '{
    {32'h80000000, 32'h00000020, 32'hFFFFFFFF},
    {32'h80000000, 32'h00000000, 32'h80000000},
    {32'h80000000, 32'h00000001, 32'hC0000000},
    {32'h80000000, 32'h0000001F, 32'hFFFFFFFF},
    {32'h80000000, 32'h00000021, 32'hFFFFFFFF},
    {32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {32'h7FFFFFFF, 32'h0000001F, 32'h00000000},
    {32'h7FFFFFFF, 32'h00000020, 32'h00000000},
    {32'h7FFFFFFF, 32'h00000001, 32'h3FFFFFFF},
    {32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    {32'h12345678, 32'h00000004, 32'h01234567},
    {32'hF0000000, 32'h00000004, 32'hFF000000},
    {32'h00000000, 32'hFFFFFFFF, 32'h00000000},
    {32'h00000000, 32'h00000005, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000007, 32'hFFFFFFFF},
    {32'h12345678, 32'h00000000, 32'h12345678},
    {32'hDEADBEEF, 32'h00000100, 32'hFFFFFFFF},
    {32'h40000000, 32'h00000021, 32'h00000000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [127:0] dataIn = '0;
  logic [127:0] countIn = '0;
  logic validOut;
  logic [DEST_W-1:0] resultOut;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vsra_unit #(.DEST_W(DEST_W)) u0 (
    .clk(clk), .rst(rst), .validIn(validIn), .dataIn(dataIn),
    .countIn(countIn), .validOut(validOut), .resultOut(resultOut)
  );

  task automatic check(input string req, input logic [DEST_W-1:0] act,
                       input logic [DEST_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [31:0] d, input logic [31:0] c);
    if (c >= 32)     return "R2";
    else if (c == 0) return "R3";
    else if (d == 0) return "R4";
    else             return "R1";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DEST_W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 reset validOut", validOut, 0);
    check("R7 reset result", resultOut, '0);

    // table walk, entries rotated across all lanes
    for (int i = 0; i < NV; i++) begin
      validIn = 1'b1;
      for (int k = 0; k < 4; k++) begin
        dataIn [k*32 +: 32] = VEC[(i+k)%NV][95:64];
        countIn[k*32 +: 32] = VEC[(i+k)%NV][63:32];
      end
      @(negedge clk);
      validIn = 1'b0;
      check("R6 validOut after validIn", validOut, 1);
      for (int k = 0; k < 4; k++) begin
        check(tagOf(VEC[(i+k)%NV][95:64], VEC[(i+k)%NV][63:32]),
              resultOut[k*32 +: 32], VEC[(i+k)%NV][31:0]);
      end
      check("R5 upper bits", resultOut >> 128, '0);
    end

    // R8 / R6: idle cycles keep result, validOut low
    held = resultOut;
    dataIn = {4{32'h80000000}};
    countIn = '0;
    repeat (3) begin
      @(negedge clk);
      check("R6 idle validOut", validOut, 0);
      check("R8 idle hold", resultOut, held);
    end

    // R2: top lane full-width count
    validIn = 1'b1;
    dataIn  = {32'h80000000, 96'h0};
    countIn = {32'h00000020, 96'h0};
    @(negedge clk);
    validIn = 1'b0;
    check("R2 top lane count 0x20", resultOut,
          {128'h0, 128'hFFFFFFFF_00000000_00000000_00000000});

    // R7: reset mid-stream
    validIn = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    rst = 1'b0;
    check("R7 reset clears validOut", validOut, 0);
    check("R7 reset clears result", resultOut, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule